// File: doc/BRIEF.md
# Byte-Image Checksum Engine

This block walks a stream of bytes that make up a memory image and forms an additive integrity code over them. Each accepted byte is added into a register whose width equals the byte width, and any carry out of the top bit is dropped. When the image is closed, the engine reports the two's complement of that running total. Appending that value after the data makes the sum of data plus code come to zero.

The same datapath serves two uses, chosen per image by `mode_i`. In generate mode (`mode_i` = 0) the data bytes are streamed in and the code byte to append is read from `sum_o`. In check mode (`mode_i` = 1) the data bytes and then the stored code byte are streamed in. `pass_o` then reports whether the whole total is zero. A nonzero total means the contents are corrupt.

The running total clears itself when an image closes, so images can follow one another with no gap cycle. The reset input is asynchronous and active low, and the block releases it internally in step with the clock.

Top module: `image_checksum_engine`

## Requirements
- R1: A byte is accepted on a rising edge where `byte_vld_i` is 1. The running total is the sum of all accepted bytes of the image, modulo 2^W_DATA, with the carry discarded.
- R2: In the cycle where `done_o` is 1, `sum_o` equals (2^W_DATA − total) mod 2^W_DATA, where the total includes the closing byte. `sum_o` keeps that value until the next `done_o`.
- R3: An image closes on the rising edge where `last_i` is 1. `done_o` is 1 in exactly the cycle after that edge, and 0 otherwise, unless the next edge also closes an image. A byte with `byte_vld_i` = 1 and `last_i` = 1 in the same cycle is included in the image it closes.
- R4: In check mode (`mode_i` = 1 in the closing cycle), `pass_o` is 1 together with `done_o` when the total is zero, and 0 when the total is nonzero.
- R5: In generate mode (`mode_i` = 0 in the closing cycle), `pass_o` is 0 with `done_o`.
- R6: The total clears when an image closes. An image that starts on the very next edge is summed on its own.
- R7: `last_i` = 1 with `byte_vld_i` = 0 closes the image without adding `byte_i`. An empty image therefore gives `sum_o` = 0x00, and `pass_o` = 1 in check mode.
- R8: After `done_o`, `pass_o` holds its value through idle cycles. It drops to 0 after the edge that accepts the first beat of the next image (a valid byte or a closing marker), unless that same edge closes the image.
- R9: Cycles with `byte_vld_i` = 0 and `last_i` = 0 have no effect on the results, whatever `byte_i` is.
- R10: While reset is held, `done_o`, `pass_o` and `sum_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low, released in step with the clock |
| mode_i | input | 1 | 0 = generate the code byte, 1 = check an image that includes its code byte |
| byte_vld_i | input | 1 | `byte_i` carries an image byte this cycle |
| byte_i | input | W_DATA | Image byte |
| last_i | input | 1 | Closes the current image this cycle |
| sum_o | output | W_DATA | Two's complement of the closed image's total |
| done_o | output | 1 | One-cycle pulse after an image closes |
| pass_o | output | 1 | Check-mode result: total was zero |

## Verification
The bench uses the default W_DATA = 8 and RST_STAGES = 2. With 8-bit bytes, random images wrap the total many times over, and a correct appended code byte drives the total to exactly zero. Directed images cover the empty image, closing by marker alone, corrupted code bytes, one-byte images in consecutive cycles and idle cycles carrying junk bytes. The two-stage reset release is short enough to check the held-reset outputs directly.

// File: rtl/imgsum_pkg.sv
package imgsum_pkg;
  typedef enum logic {
    MODE_GEN = 1'b0,
    MODE_CHK = 1'b1
  } sum_mode_e;
endpackage

// File: rtl/imgsum_rst_sync.sv
module imgsum_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_chain
      always_comb chain_d = {chain_q[LAST-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_ok_o = chain_q[LAST];
endmodule

// File: rtl/imgsum_accum.sv
module imgsum_accum #(
  parameter int W_DATA = 8
) (
  input  logic              clk,
  input  logic              rst_ok,
  input  logic              take_i,
  input  logic [W_DATA-1:0] byte_i,
  input  logic              close_i,
  output logic [W_DATA-1:0] total_o,
  output logic              start_o,
  output logic [W_DATA-1:0] acc_o
);
  logic [W_DATA-1:0] acc_q, acc_d;
  logic              open_q, open_d;
  logic              beat_en;
  logic [W_DATA-1:0] addend;

  assign beat_en = take_i | close_i;
  assign addend  = take_i ? byte_i : '0;
  assign total_o = acc_q + addend;
  assign start_o = beat_en & ~open_q;
  assign acc_o   = acc_q;

  always_comb begin
    acc_d  = acc_q;
    open_d = open_q;
    if (beat_en) begin
      acc_d  = close_i ? '0 : total_o;
      open_d = ~close_i;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      acc_q  <= '0;
      open_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      open_q <= open_d;
    end
  end
endmodule

// File: rtl/imgsum_verdict.sv
module imgsum_verdict
  import imgsum_pkg::*;
#(
  parameter int W_DATA = 8
) (
  input  logic              clk,
  input  logic              rst_ok,
  input  logic              close_i,
  input  logic              start_i,
  input  sum_mode_e         mode_i,
  input  logic [W_DATA-1:0] total_i,
  output logic              done_o,
  output logic [W_DATA-1:0] sum_o,
  output logic              pass_o
);
  logic              done_q, done_d;
  logic [W_DATA-1:0] sum_q, sum_d;
  logic              pass_q, pass_d;
  logic              total_zero;
  logic [W_DATA-1:0] neg_total;

  assign total_zero = (total_i == '0);
  assign neg_total  = '0 - total_i;

  always_comb begin
    done_d = close_i;
    sum_d  = sum_q;
    pass_d = pass_q;
    if (close_i) begin
      sum_d  = neg_total;
      pass_d = (mode_i == MODE_CHK) & total_zero;
    end else if (start_i) begin
      pass_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      done_q <= 1'b0;
      sum_q  <= '0;
      pass_q <= 1'b0;
    end else begin
      done_q <= done_d;
      sum_q  <= sum_d;
      pass_q <= pass_d;
    end
  end

  assign done_o = done_q;
  assign sum_o  = sum_q;
  assign pass_o = pass_q;

  a_r4_pass_means_zero_code: assert property (@(posedge clk) disable iff (!rst_ok)
    (done_q && pass_q) |-> (sum_q == '0));
  a_r8_pass_rises_only_at_done: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(pass_q) |-> done_q);
endmodule

// File: rtl/image_checksum_engine.sv
module image_checksum_engine
  import imgsum_pkg::*;
#(
  parameter int W_DATA     = 8,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              byte_vld_i,
  input  logic [W_DATA-1:0] byte_i,
  input  logic              last_i,
  output logic [W_DATA-1:0] sum_o,
  output logic              done_o,
  output logic              pass_o
);
  logic              rst_ok;
  logic [W_DATA-1:0] total;
  logic [W_DATA-1:0] acc_now;
  logic              start;
  sum_mode_e         mode_e;

  assign mode_e = sum_mode_e'(mode_i);

  imgsum_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_ok_o (rst_ok)
  );

  imgsum_accum #(.W_DATA(W_DATA)) u_accum (
    .clk     (clk),
    .rst_ok  (rst_ok),
    .take_i  (byte_vld_i),
    .byte_i  (byte_i),
    .close_i (last_i),
    .total_o (total),
    .start_o (start),
    .acc_o   (acc_now)
  );

  imgsum_verdict #(.W_DATA(W_DATA)) u_verdict (
    .clk     (clk),
    .rst_ok  (rst_ok),
    .close_i (last_i),
    .start_i (start),
    .mode_i  (mode_e),
    .total_i (total),
    .done_o  (done_o),
    .sum_o   (sum_o),
    .pass_o  (pass_o)
  );

  a_r3_done_follows_last: assert property (@(posedge clk) disable iff (!rst_ok)
    last_i |=> done_o);
  a_r3_done_needs_last: assert property (@(posedge clk) disable iff (!rst_ok)
    done_o |-> $past(last_i));
  a_r6_total_cleared_at_done: assert property (@(posedge clk) disable iff (!rst_ok)
    done_o |-> (acc_now == '0));
  a_r5_generate_never_passes: assert property (@(posedge clk) disable iff (!rst_ok)
    (done_o && !$past(mode_i)) |-> !pass_o);
endmodule

// File: tb/image_checksum_engine_test.sv
`timescale 1ns/1ps
module image_checksum_engine_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_i, byte_vld_i, last_i;
  logic [7:0] byte_i;
  logic [7:0] sum_o;
  logic       done_o, pass_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] img [0:31];

  always #2.5 clk = ~clk;

  image_checksum_engine #(.W_DATA(8), .RST_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .last_i(last_i), .sum_o(sum_o), .done_o(done_o), .pass_o(pass_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] neg8(input logic [7:0] x);
    return 8'(9'h100 - {1'b0, x});
  endfunction

  // One beat, driven after a falling edge, held through the next rising edge.
  task automatic beat(input logic m, input logic v, input logic l, input logic [7:0] b);
    mode_i = m; byte_vld_i = v; last_i = l; byte_i = b;
    @(negedge clk);
  endtask

  task automatic idle_junk(input int n);
    for (int i = 0; i < n; i++) beat(1'b0, 1'b0, 1'b0, 8'($urandom));
  endtask

  // n data bytes; check mode appends a code byte (optionally corrupted)
  task automatic run_image(input logic m, input int n, input bit corrupt,
                           input bit by_marker, input bit gaps, input string tag);
    logic [7:0] tot;
    logic [7:0] code;
    int cnt;
    tot = 8'h00;
    cnt = n;
    for (int i = 0; i < n; i++) begin
      img[i] = 8'($urandom);
      tot = tot + img[i];
    end
    if (m) begin
      code = neg8(tot);
      if (corrupt) code = code + 8'(1 + $urandom_range(0, 254));
      img[cnt] = code;
      tot = tot + code;
      cnt++;
    end
    if (cnt == 0) by_marker = 1'b1;
    for (int i = 0; i < cnt; i++) begin
      if (gaps && ($urandom_range(0, 3) == 0)) idle_junk($urandom_range(1, 3));
      beat(m, 1'b1, (!by_marker && i == cnt - 1), img[i]);
    end
    if (by_marker) beat(m, 1'b0, 1'b1, 8'($urandom));
    chk({tag, " R3 done after close"}, 32'(done_o), 1);
    chk({tag, " R2 R1 code byte"}, 32'(sum_o), 32'(neg8(tot)));
    if (m) chk({tag, " R4 pass verdict"}, 32'(pass_o), 32'(tot == 8'h00));
    else   chk({tag, " R5 generate pass low"}, 32'(pass_o), 0);
    idle_junk(1);
    chk({tag, " R3 done single cycle"}, 32'(done_o), 0);
    chk({tag, " R9 R2 result held idle"}, 32'(sum_o), 32'(neg8(tot)));
    chk({tag, " R8 pass held idle"}, 32'(pass_o), 32'(m && tot == 8'h00));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    rst_n = 1'b0; mode_i = 0; byte_vld_i = 0; last_i = 0; byte_i = 8'h00;
    repeat (3) @(negedge clk);
    byte_vld_i = 1; last_i = 1; byte_i = 8'h55;
    @(negedge clk);
    chk("R10 reset done", 32'(done_o), 0);
    chk("R10 reset pass", 32'(pass_o), 0);
    chk("R10 reset sum", 32'(sum_o), 0);
    byte_vld_i = 0; last_i = 0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7 empty images in both modes
    run_image(1'b0, 0, 0, 1, 0, "empty gen R7");
    run_image(1'b1, 0, 0, 1, 0, "empty chk R7");
    // R7 marker close ignores byte on the marker beat
    beat(1'b0, 1'b1, 1'b0, 8'h10);
    beat(1'b0, 1'b0, 1'b1, 8'hEE);
    chk("R7 marker ignores byte_i", 32'(sum_o), 32'h0F0);
    // R1 wrap: 0xFF + 0x02 = 0x01 -> code 0xFF
    beat(1'b0, 1'b1, 1'b0, 8'hFF);
    beat(1'b0, 1'b1, 1'b1, 8'h02);
    chk("R1 carry dropped", 32'(sum_o), 32'h0FF);
    chk("R3 last byte included", 32'(done_o), 1);

    // R8: a passing check, then the first beat of the next image clears pass
    run_image(1'b1, 5, 0, 0, 0, "chk pass R8");
    beat(1'b1, 1'b1, 1'b0, 8'h21);
    chk("R8 pass cleared at start", 32'(pass_o), 0);
    chk("R8 sum held until done", 32'(done_o), 0);
    beat(1'b1, 1'b1, 1'b1, 8'hDF);
    chk("R4 two-byte zero total", 32'(pass_o), 1);

    // R6 back-to-back single-byte images
    beat(1'b1, 1'b1, 1'b1, 8'h00);
    beat(1'b0, 1'b1, 1'b1, 8'h05);
    chk("R6 first image code", 32'(sum_o), 32'h0FB);
    beat(1'b0, 1'b1, 1'b1, 8'h03);
    chk("R6 second image separate", 32'(sum_o), 32'h0FD);
    chk("R6 done again", 32'(done_o), 1);
    idle_junk(2);

    // corrupted check images
    run_image(1'b1, 7, 1, 0, 1, "corrupt R4");
    run_image(1'b1, 1, 1, 1, 0, "corrupt marker R4");

    // random mix
    for (int k = 0; k < 300; k++) begin
      run_image(1'($urandom_range(0, 1)), $urandom_range(0, 20),
                ($urandom_range(0, 3) == 0), ($urandom_range(0, 4) == 0),
                1'b1, "random R1");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule